// File: doc/BRIEF.md
# Two-Stage Bank Decimation Capture

This block takes the sample stream of a dual-bank converter and thins it to a rate that a slow capture memory or a reconstruction DAC can accept. Each bank delivers a 6-bit word together with a one-cycle ready strobe. The strobes of the two banks fall on opposite cycles of the sample clock, so each bank runs at half the sample rate. A select input picks one bank. Only that bank's strobes and words reach the decimator.

Decimation takes place in two cascaded stages, and everything runs in the sample-clock domain with the strobes used as clock enables. The first stage keeps one word out of every four accepted strobes. The second stage then keeps one out of every 2, 4 or 8 first-stage words, as chosen by a 2-bit rate code. With bank strobes on every other cycle, the total decimation relative to the sample clock is 16, 32 or 64. The output is a registered word with a one-cycle capture strobe that a memory write enable or a DAC latch can use directly. Any change of bank or rate code restarts both stages, so the next output comes only after a complete new period.

Top module: `decim_capture`

## Requirements
- R1: Synchronous active-high reset drives `cap_data` to 0 and `cap_strobe` to 0. Both stage counters restart from zero.
- R2: With `bank_sel` = 0 only `rdy_a`/`data_a` are used. With `bank_sel` = 1 only `rdy_b`/`data_b` are used. Strobes and data of the unselected bank have no effect on the outputs.
- R3: The first stage passes on every fourth accepted strobe, counted from reset or from the last restart. It passes on the word that came with that strobe.
- R4: With `rate_sel` = 2'b11 the second stage divides by 2, so an output is produced on every 8th accepted strobe. That is 16 sample clocks when strobes come every other cycle.
- R5: With `rate_sel` = 2'b10 an output is produced on every 16th accepted strobe. With `rate_sel` = 2'b00 or 2'b01 an output is produced on every 32nd accepted strobe. These correspond to 32 and 64 sample clocks.
- R6: `cap_data` and `cap_strobe` change on the rising edge after the edge that samples the qualifying strobe. `cap_data` then equals the word sampled with that strobe.
- R7: `cap_strobe` is high for exactly one cycle per output word. `cap_data` holds its value in every cycle in which `cap_strobe` is low.
- R8: A clock edge at which `bank_sel` or `rate_sel` differs from its value at the previous edge restarts both counters and cancels any word in flight. A strobe sampled at that edge is discarded. The first output after the change comes on the full-period count of strobes sampled after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | 0 selects bank A, 1 selects bank B |
| rate_sel | input | 2 | Second-stage ratio code: 11 = 2, 10 = 4, 00/01 = 8 |
| rdy_a | input | 1 | Bank A ready strobe, one cycle per word |
| data_a | input | 6 | Bank A word |
| rdy_b | input | 1 | Bank B ready strobe, one cycle per word |
| data_b | input | 6 | Bank B word |
| cap_data | output | 6 | Registered decimated word |
| cap_strobe | output | 1 | One-cycle pulse marking a new `cap_data` |

## Verification
A miscounting stage would show up as a `cap_strobe` off by whole strobes. This would appear at the very first output after reset or after a restart, which is at most 32 bank strobes away. A wrong bank or a misplaced data register would show up as a `cap_data` word that differs from the one driven with the qualifying strobe, visible on that same pulse. A missing restart would show up as a premature pulse in the first period after a select change. The bench drives distinct words on both banks every cycle, so cross-bank leakage changes the captured value at once.

// File: rtl/decim_capture_pkg.sv
package decim_capture_pkg;

  // Second-stage ratio codes; two codes share the slowest ratio.
  typedef enum logic [1:0] {
    RATE_SLOW_A = 2'b00,
    RATE_SLOW_B = 2'b01,
    RATE_MID    = 2'b10,
    RATE_FAST   = 2'b11
  } rate_code_e;

  localparam int unsigned RATIO_FAST = 2;
  localparam int unsigned RATIO_MID  = 4;
  localparam int unsigned RATIO_SLOW = 8;

  function automatic int unsigned second_ratio(input logic [1:0] code);
    case (rate_code_e'(code))
      RATE_FAST: return RATIO_FAST;
      RATE_MID:  return RATIO_MID;
      default:   return RATIO_SLOW;
    endcase
  endfunction

endpackage

// File: rtl/bank_pick.sv
module bank_pick #(
  parameter int DW = 6
) (
  input  logic          bank_sel,
  input  logic          rdy_a,
  input  logic [DW-1:0] data_a,
  input  logic          rdy_b,
  input  logic [DW-1:0] data_b,
  output logic          pick_vld,
  output logic [DW-1:0] pick_data
);
  always_comb begin
    if (bank_sel) begin
      pick_vld  = rdy_b;
      pick_data = data_b;
    end else begin
      pick_vld  = rdy_a;
      pick_data = data_a;
    end
  end
endmodule

// File: rtl/cfg_watch.sv
module cfg_watch #(
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_sel,
  input  logic [RW-1:0] rate_sel,
  output logic          restart
);
  logic          bank_q;
  logic [RW-1:0] rate_q;

  always_ff @(posedge clk) begin
    bank_q <= bank_sel;
    rate_q <= rate_sel;
  end

  assign restart = !rst && ((bank_sel != bank_q) || (rate_sel != rate_q));
endmodule

// File: rtl/decim_stage.sv
module decim_stage #(
  parameter int DW = 6,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] ratio_m1,
  output logic          out_vld,
  output logic [DW-1:0] out_data
);
  logic [CW-1:0] cnt;
  logic          last;

  assign last = in_vld && (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else if (clr) begin
      cnt     <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= last;
      if (in_vld) cnt <= last ? '0 : cnt + 1'b1;
      if (last) out_data <= in_data;
    end
  end

  // R3: the count never passes the programmed terminal value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (cnt <= ratio_m1));

  // R7: output pulse lasts one cycle
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  // R7: word holds between pulses
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!out_vld && !$past(rst)) |-> $stable(out_data));

  // R6: every output pulse follows an accepted input one edge earlier
  p_cause_r6: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld));
endmodule

// File: rtl/decim_capture.sv
module decim_capture
  import decim_capture_pkg::*;
#(
  parameter int DW          = 6,
  parameter int FIRST_RATIO = 4,
  parameter int RW          = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_sel,
  input  logic [RW-1:0] rate_sel,
  input  logic          rdy_a,
  input  logic [DW-1:0] data_a,
  input  logic          rdy_b,
  input  logic [DW-1:0] data_b,
  output logic [DW-1:0] cap_data,
  output logic          cap_strobe
);
  localparam int C1W = $clog2(FIRST_RATIO);
  localparam int C2W = $clog2(RATIO_SLOW);

  logic          pick_vld;
  logic [DW-1:0] pick_data;
  logic          restart;
  logic          s1_vld;
  logic [DW-1:0] s1_data;
  logic [C2W-1:0] s2_m1;

  assign s2_m1 = C2W'(second_ratio(rate_sel[1:0]) - 1);

  bank_pick #(.DW(DW)) u_pick (
    .bank_sel (bank_sel),
    .rdy_a    (rdy_a),
    .data_a   (data_a),
    .rdy_b    (rdy_b),
    .data_b   (data_b),
    .pick_vld (pick_vld),
    .pick_data(pick_data)
  );

  cfg_watch #(.RW(RW)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .bank_sel(bank_sel),
    .rate_sel(rate_sel),
    .restart (restart)
  );

  decim_stage #(.DW(DW), .CW(C1W)) u_stage1 (
    .clk     (clk),
    .rst     (rst),
    .clr     (restart),
    .in_vld  (pick_vld),
    .in_data (pick_data),
    .ratio_m1(C1W'(FIRST_RATIO - 1)),
    .out_vld (s1_vld),
    .out_data(s1_data)
  );

  decim_stage #(.DW(DW), .CW(C2W)) u_stage2 (
    .clk     (clk),
    .rst     (rst),
    .clr     (restart),
    .in_vld  (s1_vld),
    .in_data (s1_data),
    .ratio_m1(s2_m1),
    .out_vld (cap_strobe),
    .out_data(cap_data)
  );

  // R8: a restart leaves no strobe in flight
  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> !cap_strobe);

  // R1: outputs are cleared in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!cap_strobe && cap_data == '0));
endmodule

// File: tb/decim_capture_tb.sv
module decim_capture_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bank_sel = 1'b0;
  logic [1:0] rate_sel = 2'b11;
  logic       rdy_a = 1'b0, rdy_b = 1'b0;
  logic [5:0] data_a = '0, data_b = '0;
  logic [5:0] cap_data;
  logic       cap_strobe;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference state
  int         m_cnt = 0;
  bit         m_pend_v = 0, m_out_v = 0;
  logic [5:0] m_pend_d = '0, m_out_d = '0;
  logic       m_bank_q = 0;
  logic [1:0] m_rate_q = '0;
  bit         phase = 0;
  logic [5:0] seed = 6'd1;

  always #(CLK_PERIOD/2) clk = ~clk;

  decim_capture u_dut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .rate_sel(rate_sel),
    .rdy_a(rdy_a), .data_a(data_a), .rdy_b(rdy_b), .data_b(data_b),
    .cap_data(cap_data), .cap_strobe(cap_strobe)
  );

  function automatic int total_ratio(input logic [1:0] code);
    case (code)
      2'b11:   return 8;
      2'b10:   return 16;
      default: return 32;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(input string tag);
    bit         sv;
    logic [5:0] sd;
    phase  = !phase;
    seed   = seed * 6'd5 + 6'd3;
    rdy_a  = phase;
    rdy_b  = !phase;
    data_a = seed;
    data_b = ~seed;
    sv = bank_sel ? rdy_b : rdy_a;
    sd = bank_sel ? data_b : data_a;
    @(posedge clk);
    if (bank_sel != m_bank_q || rate_sel != m_rate_q) begin
      m_cnt = 0; m_pend_v = 0; m_out_v = 0;
    end else begin
      m_out_v = m_pend_v;
      if (m_pend_v) m_out_d = m_pend_d;
      m_pend_v = 0;
      if (sv) begin
        m_cnt++;
        if (m_cnt == total_ratio(rate_sel)) begin
          m_cnt = 0; m_pend_v = 1; m_pend_d = sd;
        end
      end
    end
    m_bank_q = bank_sel;
    m_rate_q = rate_sel;
    @(negedge clk);
    check({tag, " R7 strobe"}, 32'(cap_strobe), 32'(m_out_v));
    check({tag, " R6 data"}, 32'(cap_data), 32'(m_out_d));
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset strobe", 32'(cap_strobe), 0);
    check("R1 reset data", 32'(cap_data), 0);
    rst = 1'b0;
    m_cnt = 0; m_pend_v = 0; m_out_v = 0; m_out_d = '0;
    m_bank_q = bank_sel; m_rate_q = rate_sel;
  endtask

  task automatic t_rate16;   // R3 R4
    bank_sel = 0; rate_sel = 2'b11;
    run(80, "R3 R4 div16");
  endtask

  task automatic t_rate32;   // R5
    rate_sel = 2'b10;
    run(140, "R5 div32");
  endtask

  task automatic t_rate64;   // R5 both slow codes
    rate_sel = 2'b00;
    run(200, "R5 div64 code00");
    rate_sel = 2'b01;
    run(200, "R5 div64 code01");
  endtask

  task automatic t_bank_b;   // R2
    bank_sel = 1; rate_sel = 2'b11;
    run(100, "R2 bankB");
    bank_sel = 0;
    run(60, "R2 bankA");
  endtask

  task automatic t_restart;  // R8
    rate_sel = 2'b11;
    run(11, "R8 pre");
    rate_sel = 2'b10;
    run(70, "R8 after rate change");
    run(25, "R8 mid");
    bank_sel = 1;
    run(70, "R8 after bank change");
  endtask

  initial begin
    t_reset();
    t_rate16();
    t_rate32();
    t_rate64();
    t_bank_b();
    t_restart();
    t_reset();
    rate_sel = 2'b11;
    m_rate_q = rate_sel;
    run(40, "R1 R4 after second reset");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule